// File: doc/BRIEF.md
# Two-Read One-Write Register File with Selectable Forwarding

This block holds a bank of general-purpose data words for a processor pipeline. It serves two independent read ports and one write port. Both reads are combinational from the index to the data. The write takes effect at the rising clock edge. Entry zero is hard-wired to zero. A write aimed at it is dropped, and a read of it always yields zero.

A build-time parameter sets the order of the reads and the write within one cycle.

- **Reads before the write.** With `BYPASS_EN = 0`, a read always returns the value held before the cycle's write. The new value appears from the next cycle.
- **Write before the reads.** With `BYPASS_EN = 1`, a read whose index equals the index of an active write receives the incoming write data in the same cycle. A read at any other index receives the stored word.

The two ports make this choice independently, so either port, both ports or neither may forward in a given cycle. A synchronous reset clears every entry.

Top module: `regfile_2r1w`

## Requirements
- R1: The file has NUM_REGS (default 32) entries, addressed by a 5-bit index. A write with `wrEn`=1 stores `wrData` at `wrIdx` on the rising edge, and from the next cycle a read of that index returns it on either port.
- R2: A write to index 0 is discarded. A read of index 0 returns zero on both ports in every cycle, including a cycle with a same-cycle write to index 0, and in both modes.
- R3: With BYPASS_EN=0, a read whose index equals the active write index returns the value stored before that write in the same cycle. The new value is returned from the next cycle.
- R4: With BYPASS_EN=1, a read whose index equals a nonzero active write index returns `wrData` in the same cycle.
- R5: With BYPASS_EN=1, a read whose index differs from the write index returns the stored value.
- R6: The two read ports are independent. In one cycle both may forward the write data, or one may forward while the other returns a stored value.
- R7: While `rst`=1 at a rising edge, all entries become zero, and every read afterwards returns zero until a new write.
- R8: With `wrEn`=0, no entry changes, whatever the values on `wrIdx` and `wrData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write occurs on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all entries |
| rdIdxA | input | 5 | Read index, port A |
| rdIdxB | input | 5 | Read index, port B |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Write index |
| wrData | input | DATA_W (32) | Write data |
| rdDataA | output | DATA_W (32) | Read data, port A |
| rdDataB | output | DATA_W (32) | Read data, port B |

## Verification
The hardest case is a cycle that both writes and reads the same index, because the result depends on the mode. The bench therefore drives identical stimulus into a forwarding instance and a non-forwarding instance side by side. It aims both read ports at the write index, splits them between a matching index and a stale one, and aims them at index 0 during a write to index 0. Disabled writes carrying live-looking indices and data are followed by reads of those indices. A mid-run reset is followed by reads of entries that were written earlier.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Strobes that the control logic hands to the datapath.
  typedef struct packed {
    logic wrEn;   // qualified write, never to entry zero
    logic fwdA;   // port A takes the incoming write data
    logic fwdB;   // port B takes the incoming write data
    logic zeroA;  // port A addresses the constant entry
    logic zeroB;  // port B addresses the constant entry
  } rfStrobe_t;

endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl #(
  parameter int IDX_W     = 5,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [IDX_W-1:0]       rdIdxA,
  input  logic [IDX_W-1:0]       rdIdxB,
  output regfile_pkg::rfStrobe_t strobe
);

  logic wrLive;

  assign wrLive = wrEn && (wrIdx != '0);

  always_comb begin
    strobe.wrEn  = wrLive;
    strobe.zeroA = (rdIdxA == '0);
    strobe.zeroB = (rdIdxB == '0);
    strobe.fwdA  = 1'b0;
    strobe.fwdB  = 1'b0;
    if (BYPASS_EN) begin
      strobe.fwdA = wrLive && (rdIdxA == wrIdx);
      strobe.fwdB = wrLive && (rdIdxB == wrIdx);
    end
  end

endmodule

// File: rtl/regfile_dp.sv
module regfile_dp #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 32,
  parameter int IDX_W     = 5,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  regfile_pkg::rfStrobe_t strobe,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [IDX_W-1:0]       rdIdxA,
  input  logic [IDX_W-1:0]       rdIdxB,
  output logic [DATA_W-1:0]      rdDataA,
  output logic [DATA_W-1:0]      rdDataB
);

  // Entry zero has no storage; it is supplied by the read mux.
  logic [DATA_W-1:0] store [1:NUM_REGS-1];

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        store[gi] <= '0;
      end else if (strobe.wrEn && (wrIdx == IDX_W'(gi))) begin
        store[gi] <= wrData;
      end
    end
  end

  function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] val;
    val = '0;
    for (int k = 1; k < NUM_REGS; k++) begin
      if (idx == IDX_W'(k)) val = store[k];
    end
    return val;
  endfunction

  always_comb begin
    if (strobe.zeroA)     rdDataA = '0;
    else if (strobe.fwdA) rdDataA = wrData;
    else                  rdDataA = pick(rdIdxA);
    if (strobe.zeroB)     rdDataB = '0;
    else if (strobe.fwdB) rdDataB = wrData;
    else                  rdDataB = pick(rdIdxB);
  end

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (rdIdxA == '0) |-> (rdDataA == '0)); // R2
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (rdIdxB == '0) |-> (rdDataB == '0)); // R2
  AST_WRITE_SEEN_A: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.wrEn) && !$past(rst) && (rdIdxA == $past(wrIdx)) && !strobe.fwdA)
      |-> (rdDataA == $past(wrData))); // R1
  AST_WRITE_SEEN_B: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.wrEn) && !$past(rst) && (rdIdxB == $past(wrIdx)) && !strobe.fwdB)
      |-> (rdDataB == $past(wrData))); // R1
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
    (BYPASS_EN && strobe.wrEn && (rdIdxA == wrIdx)) |-> (rdDataA == wrData)); // R4
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst)
    (BYPASS_EN && strobe.wrEn && (rdIdxB == wrIdx)) |-> (rdDataB == wrData)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    ($past(rst) && !strobe.fwdA) |-> (rdDataA == '0)); // R7

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 32,
  parameter bit BYPASS_EN = 1'b1,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  regfile_pkg::rfStrobe_t strobe;

  regfile_ctrl #(.IDX_W(IDX_W), .BYPASS_EN(BYPASS_EN)) u_ctrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .strobe(strobe)
  );

  regfile_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
               .BYPASS_EN(BYPASS_EN)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: tb/regfile_2r1w_bench.sv
`timescale 1ns/100ps
module regfile_2r1w_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] fA, fB, nA, nB;

  always #2.5 clk = ~clk;

  regfile_2r1w #(.BYPASS_EN(1'b1)) u_regfile_2r1w (
    .clk(clk), .rst(rst), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .rdDataA(fA), .rdDataB(fB));

  regfile_2r1w #(.BYPASS_EN(1'b0)) u_regfile_2r1w_normal (
    .clk(clk), .rst(rst), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .rdDataA(nA), .rdDataB(nB));

  typedef struct {
    string       tag;
    logic [31:0] eFA, eFB, eNA, eNB;
  } item_t;

  item_t       q[$];
  logic [31:0] model [32];
  int          errors = 0, checks = 0;
  bit          finished = 0;

  task automatic cmp(string tag, string port, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected reads.
  task automatic step(string tag, bit we, int wi, logic [31:0] wd, int ra, int rb);
    item_t it;
    @(negedge clk);
    wrEn = we; wrIdx = 5'(wi); wrData = wd; rdIdxA = 5'(ra); rdIdxB = 5'(rb);
    it.tag = tag;
    it.eNA = (ra == 0) ? '0 : model[ra];
    it.eNB = (rb == 0) ? '0 : model[rb];
    it.eFA = (we && wi != 0 && ra == wi) ? wd : it.eNA;
    it.eFB = (we && wi != 0 && rb == wi) ? wd : it.eNB;
    q.push_back(it);
    if (we && wi != 0) model[wi] = wd;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  // Monitor: compares the queued expectations a little after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cmp(it.tag, "fwdA", fA, it.eFA);
        cmp(it.tag, "fwdB", fB, it.eFB);
        cmp(it.tag, "normA", nA, it.eNA);
        cmp(it.tag, "normB", nB, it.eNB);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step("R7 reset state", 0, 0, 0, 5, 31);
    // R1 fill every entry, then read each back next cycle on both ports
    for (int i = 1; i < 32; i++) step("R1 fill", 1, i, 32'hA500_0000 + i, 0, 0);
    for (int i = 1; i < 32; i++) step("R1 readback", 0, 0, 0, i, 32 - i);
    // R2 write to zero dropped, read of zero with same-cycle zero write
    step("R2 zero write", 1, 0, 32'hDEAD_BEEF, 0, 0);
    step("R2 zero readback", 0, 0, 0, 0, 1);
    // R3/R4 same-cycle read at the write index
    step("R3 R4 same-cycle port A", 1, 7, 32'h1111_0007, 7, 8);
    step("R3 next-cycle", 0, 0, 0, 7, 7);
    // R6 both ports forward
    step("R6 both match", 1, 12, 32'h2222_000C, 12, 12);
    // R5 R6 split: one matches, one stale
    step("R5 R6 split", 1, 20, 32'h3333_0014, 19, 20);
    step("R5 no match", 1, 3, 32'h4444_0003, 4, 5);
    // R8 disabled writes leave contents alone
    step("R8 disabled", 0, 9, 32'hFFFF_FFFF, 9, 10);
    step("R8 readback", 0, 10, 32'h0BAD_0BAD, 9, 10);
    // R7 mid-run reset clears stored entries
    doReset();
    step("R7 after reset", 0, 0, 0, 7, 12);
    step("R7 after reset", 0, 0, 0, 31, 3);
    step("R1 R4 post-reset write", 1, 31, 32'h5555_001F, 31, 30);
    step("R1 post-reset read", 0, 0, 0, 31, 30);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule